// File: doc/BRIEF.md
# Edge-Counting Frequency Comparator

This block decides which of two square waves runs faster: an unknown input and the hard-limited output of a frequency synthesizer. It sits inside a closed measurement loop, where its one-bit command tells a downstream frequency-word counter to step up or down. The counter's word sets the synthesizer frequency, so the synthesizer is pushed toward the unknown frequency.

Both inputs are brought into the system clock domain, and their rising edges are extracted. Each input has a small saturating counter. That counter counts the input's own rising edges since the most recent rising edge of the other input. When the unknown input collects a second edge inside one synthesizer period, the command latch is set ("raise the word"). When the synthesizer collects a second edge inside one unknown period, the latch is cleared ("lower the word").

A sticky flag reports that at least one decision has been made since reset. A one-cycle strobe marks every decision. The command has only two values, so near equal frequencies the loop makes it alternate.

Top module: `freq_edge_cmp`

## Requirements
- R1: Each input passes through a two-flop synchroniser, and a rising edge is a 0-to-1 change of the synchronised value. If an input rises just before clock edge 1, the command, flag and strobe that result from that edge update on clock edge 3.
- R2: The unknown-side counter counts rising edges of `sig_unk` since the last rising edge of `sig_syn`, and stops counting at two. A decision needs two rising edges of one input with no rising edge of the other input between them; a single edge never produces a decision.
- R3: When the unknown-side counter reaches two, `cmd_up` becomes 1 (1 = count the frequency word up).
- R4: When the synthesizer-side counter reaches two, `cmd_up` becomes 0 (0 = count the frequency word down).
- R5: If both inputs rise in the same cycle, each counter restarts at one. A single further edge on either input then completes a decision.
- R6: `decided` goes to 1 with the first decision after reset and stays at 1 until a reset.
- R7: `dec_stb` is high for exactly one cycle per decision, including a decision that leaves `cmd_up` unchanged. Once a counter has saturated, further edges on that input produce no strobe until the other input rises.
- R8: Asserting `rst_n` low clears `cmd_up`, `decided` and `dec_stb` at once. Internal reset is released on the second clock edge after `rst_n` rises. A high `srst` at a clock edge clears the counters, `cmd_up`, `decided` and `dec_stb`.
- R9: There is no equality output. Each decision overwrites the previous one, so input bursts that alternate between a faster unknown input and a faster synthesizer input toggle `cmd_up` once per burst change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srst | input | 1 | Synchronous clear of counters, command and flags |
| sig_unk | input | 1 | Unknown-frequency square wave (asynchronous) |
| sig_syn | input | 1 | Hard-limited synthesizer square wave (asynchronous) |
| cmd_up | output | 1 | 1 = raise frequency word, 0 = lower it |
| decided | output | 1 | At least one decision made since reset |
| dec_stb | output | 1 | One-cycle pulse on each decision |

## Verification
The main function is exercised with free-running square waves in which either the unknown input or the synthesizer input is clearly faster. These runs show which counter sets and which counter clears the latch. Hand-placed single pulses check three cases: a lone edge gives no decision, strict alternation of the inputs gives no decision, and coincident edges restart both counts at one. Two more patterns are used. Equal, aligned waves show that no decision is forced. Alternating fast and slow bursts show the command toggling with no equality state. A three-cycle measurement after a single rising edge pins the synchroniser latency.

// File: rtl/freq_edge_cmp_pkg.sv
package freq_edge_cmp_pkg;

  typedef enum logic {
    CMD_DOWN = 1'b0,
    CMD_UP   = 1'b1
  } cmd_e;

  localparam int unsigned N_LANES  = 2;
  localparam int unsigned LANE_UNK = 0;
  localparam int unsigned LANE_SYN = 1;

endpackage

// File: rtl/fec_rst_sync.sv
module fec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic arst_n_o
);
  logic [1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 2'b00;
    else        q <= {q[0], 1'b1};
  end

  assign arst_n_o = q[1];
endmodule

// File: rtl/fec_edge_sync.sv
module fec_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  // R1: rise is a 0-to-1 change seen after STAGES synchroniser flops
  assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/fec_edge_count.sv
module fec_edge_count #(
  parameter int unsigned TARGET = 2,
  localparam int unsigned CW    = $clog2(TARGET + 1)
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          clr,
  input  logic          self_rise,
  input  logic          other_rise,
  output logic          hit,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] TOP  = CW'(TARGET);
  localparam logic [CW-1:0] LAST = CW'(TARGET - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  // R2, R5: other input's edge restarts the count; own edge in that cycle counts as first
  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (other_rise) begin
      cnt_en = 1'b1;
      cnt_d  = self_rise ? ONE : '0;
    end else if (self_rise && (cnt_q != TOP)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hit = self_rise && !other_rise && (cnt_q == LAST) && !clr;
  assign cnt = cnt_q;
endmodule

// File: rtl/fec_decide.sv
module fec_decide
  import freq_edge_cmp_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  input  logic clr,
  input  logic hit_up,
  input  logic hit_dn,
  output logic cmd_up,
  output logic decided,
  output logic dec_stb
);
  cmd_e cmd_q, cmd_d;
  logic dec_q, dec_d;
  logic stb_q, stb_d;
  logic single;

  assign single = hit_up ^ hit_dn;

  always_comb begin
    cmd_d = cmd_q;
    dec_d = dec_q;
    stb_d = 1'b0;
    if (clr) begin
      cmd_d = CMD_DOWN;
      dec_d = 1'b0;
    end else begin
      if (hit_up && !hit_dn) cmd_d = CMD_UP;    // R3
      if (hit_dn && !hit_up) cmd_d = CMD_DOWN;  // R4
      if (single) begin
        dec_d = 1'b1;                           // R6
        stb_d = 1'b1;                           // R7
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cmd_q <= CMD_DOWN;
      dec_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      cmd_q <= cmd_d;
      dec_q <= dec_d;
      stb_q <= stb_d;
    end
  end

  assign cmd_up  = (cmd_q == CMD_UP);
  assign decided = dec_q;
  assign dec_stb = stb_q;
endmodule

// File: rtl/freq_edge_cmp.sv
module freq_edge_cmp
  import freq_edge_cmp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned EDGE_TARGET = 2,
  localparam int unsigned CW         = $clog2(EDGE_TARGET + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic srst,
  input  logic sig_unk,
  input  logic sig_syn,
  output logic cmd_up,
  output logic decided,
  output logic dec_stb
);
  logic                arst_n;
  logic [N_LANES-1:0]  raw;
  logic [N_LANES-1:0]  rise;
  logic [N_LANES-1:0]  hit;
  logic [CW-1:0]       cnt [N_LANES];

  assign raw[LANE_UNK] = sig_unk;
  assign raw[LANE_SYN] = sig_syn;

  fec_rst_sync u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .arst_n_o (arst_n)
  );

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    fec_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (arst_n),
      .din    (raw[i]),
      .rise   (rise[i])
    );
    fec_edge_count #(.TARGET(EDGE_TARGET)) u_cnt (
      .clk        (clk),
      .arst_n     (arst_n),
      .clr        (srst),
      .self_rise  (rise[i]),
      .other_rise (rise[N_LANES-1-i]),
      .hit        (hit[i]),
      .cnt        (cnt[i])
    );
  end

  fec_decide u_dec (
    .clk     (clk),
    .arst_n  (arst_n),
    .clr     (srst),
    .hit_up  (hit[LANE_UNK]),
    .hit_dn  (hit[LANE_SYN]),
    .cmd_up  (cmd_up),
    .decided (decided),
    .dec_stb (dec_stb)
  );
endmodule

// File: rtl/freq_edge_cmp_chk.sv
module freq_edge_cmp_chk #(
  parameter int unsigned TGT = 2,
  parameter int unsigned CW  = 2
) (
  input logic          clk,
  input logic          arst_n,
  input logic          srst,
  input logic          rise_u,
  input logic          rise_s,
  input logic          hit_u,
  input logic          hit_s,
  input logic [CW-1:0] cnt_u,
  input logic [CW-1:0] cnt_s,
  input logic          cmd_up,
  input logic          decided,
  input logic          dec_stb
);
  AST_UP_ON_UNK_HIT: assert property (@(posedge clk) disable iff (!arst_n || srst)
    hit_u && !hit_s |=> cmd_up); // R3
  AST_CMD_RISE_STROBED: assert property (@(posedge clk) disable iff (!arst_n || srst)
    $rose(cmd_up) |-> dec_stb); // R3
  AST_DN_ON_SYN_HIT: assert property (@(posedge clk) disable iff (!arst_n || srst)
    hit_s && !hit_u |=> !cmd_up); // R4
  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!arst_n)
    (cnt_u <= CW'(TGT)) && (cnt_s <= CW'(TGT))); // R2
  AST_COINCIDENT_RESTART: assert property (@(posedge clk) disable iff (!arst_n || srst)
    rise_u && rise_s |=> (cnt_u == CW'(1)) && (cnt_s == CW'(1))); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!arst_n || srst)
    decided |=> decided); // R6
  AST_STROBE_WITH_FLAG: assert property (@(posedge clk) disable iff (!arst_n)
    dec_stb |-> decided); // R7
  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!arst_n)
    srst |=> !cmd_up && !decided && !dec_stb); // R8
endmodule

bind freq_edge_cmp freq_edge_cmp_chk #(.TGT(EDGE_TARGET), .CW(CW)) u_chk (
  .clk     (clk),
  .arst_n  (arst_n),
  .srst    (srst),
  .rise_u  (rise[0]),
  .rise_s  (rise[1]),
  .hit_u   (hit[0]),
  .hit_s   (hit[1]),
  .cnt_u   (cnt[0]),
  .cnt_s   (cnt[1]),
  .cmd_up  (cmd_up),
  .decided (decided),
  .dec_stb (dec_stb)
);

// File: tb/freq_edge_cmp_bench.sv
`timescale 1ns/1ps
module freq_edge_cmp_bench;
  logic clk = 1'b0;
  logic rst_n, srst, sig_unk, sig_syn;
  logic cmd_up, decided, dec_stb;

  always #2 clk = ~clk;

  freq_edge_cmp u_freq_edge_cmp (
    .clk(clk), .rst_n(rst_n), .srst(srst), .sig_unk(sig_unk), .sig_syn(sig_syn),
    .cmd_up(cmd_up), .decided(decided), .dec_stb(dec_stb)
  );

  int checks = 0;
  int bad    = 0;
  bit done   = 0;

  // behavioural reference
  int hu[$];
  int hs[$];
  int m_cu, m_cs, m_cmd, m_val, m_stb, m_rs;

  // waveform generators (period 0 = manual drive)
  int pu = 0, ps = 0, cu = 0, cs = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_cu = 0; m_cs = 0; m_cmd = 0; m_val = 0; m_stb = 0;
    hu = '{0, 0, 0};
    hs = '{0, 0, 0};
  endtask

  task automatic model_tick();
    int eu, es, wu, ws;
    if (!rst_n) begin
      model_clear();
      m_rs = 0;
    end else if (m_rs < 2) begin
      model_clear();
      m_rs++;
    end else begin
      eu = (hu[1] == 1 && hu[2] == 0);
      es = (hs[1] == 1 && hs[2] == 0);
      wu = (!srst && eu && !es && m_cu == 1);
      ws = (!srst && es && !eu && m_cs == 1);
      if (srst) begin
        m_cu = 0; m_cs = 0; m_cmd = 0; m_val = 0; m_stb = 0;
      end else begin
        if (es) m_cu = eu; else if (eu && m_cu < 2) m_cu++;
        if (eu) m_cs = es; else if (es && m_cs < 2) m_cs++;
        if (wu && !ws) m_cmd = 1;
        if (ws && !wu) m_cmd = 0;
        if (wu != ws) m_val = 1;
        m_stb = (wu != ws);
      end
      hu.push_front(int'(sig_unk)); void'(hu.pop_back());
      hs.push_front(int'(sig_syn)); void'(hs.pop_back());
    end
  endtask

  task automatic step();
    @(negedge clk);
    model_tick();
    check(int'(cmd_up) == m_cmd, "R3/R4 cmd_up vs model", int'(cmd_up), m_cmd);
    check(int'(decided) == m_val, "R6 decided vs model", int'(decided), m_val);
    check(int'(dec_stb) == m_stb, "R7 dec_stb vs model", int'(dec_stb), m_stb);
    if (pu > 0) begin sig_unk = (cu < pu / 2); cu = (cu + 1) % pu; end
    if (ps > 0) begin sig_syn = (cs < ps / 2); cs = (cs + 1) % ps; end
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse(input bit u, input bit s);
    if (u) sig_unk = 1'b1;
    if (s) sig_syn = 1'b1;
    steps(3);
    sig_unk = 1'b0;
    sig_syn = 1'b0;
    steps(3);
  endtask

  task automatic do_srst();
    srst = 1'b1; step(); srst = 1'b0; step();
  endtask

  task automatic set_gen(input int a, input int b);
    pu = a; ps = b; cu = 0; cs = 0;
    if (a == 0) sig_unk = 1'b0;
    if (b == 0) sig_syn = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      bad++; checks++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    int n, tg, prev;
    rst_n = 1'b0; srst = 1'b0; sig_unk = 1'b0; sig_syn = 1'b0;
    m_rs = 0; model_clear();
    steps(3);
    check(!cmd_up && !decided && !dec_stb, "R8 reset state", int'({cmd_up, decided, dec_stb}), 0);
    rst_n = 1'b1;
    steps(6);

    // R2: one lone unknown edge gives no decision
    pulse(1, 0);
    steps(4);
    check(decided == 1'b0, "R2 single edge no decision", int'(decided), 0);

    // R1: second edge, latency of three clock edges
    sig_unk = 1'b1;
    step(); step();
    check(cmd_up == 1'b0, "R1 no change before third edge", int'(cmd_up), 0);
    step();
    check(cmd_up == 1'b1, "R1 R3 command set on third edge", int'(cmd_up), 1);
    check(dec_stb == 1'b1, "R7 strobe with decision", int'(dec_stb), 1);
    check(decided == 1'b1, "R6 flag set", int'(decided), 1);
    step();
    check(dec_stb == 1'b0, "R7 strobe lasts one cycle", int'(dec_stb), 0);
    sig_unk = 1'b0; steps(3);

    // R7: saturated counter, more edges, no strobes
    n = 0;
    for (int k = 0; k < 18; k++) begin
      if (k % 6 == 0) sig_unk = 1'b1;
      if (k % 6 == 3) sig_unk = 1'b0;
      step();
      n += int'(dec_stb);
    end
    steps(4);
    check(n == 0, "R7 R2 no strobe after saturation", n, 0);

    // R8: synchronous clear
    do_srst();
    check(!cmd_up && !decided, "R8 srst clears", int'({cmd_up, decided}), 0);

    // R2: strict alternation never decides
    for (int k = 0; k < 4; k++) begin pulse(1, 0); pulse(0, 1); end
    steps(4);
    check(decided == 1'b0, "R2 alternation no decision", int'(decided), 0);

    // R5: coincident edges restart at one, one more edge decides
    do_srst();
    pulse(1, 1);
    pulse(0, 1);
    steps(4);
    check(decided == 1'b1 && cmd_up == 1'b0, "R5 R4 coincident then syn edge", int'({decided, cmd_up}), 2);

    // R3: unknown clearly faster
    do_srst();
    set_gen(6, 20);
    steps(100);
    n = 0;
    for (int k = 0; k < 200; k++) begin step(); n += int'(dec_stb); end
    check(cmd_up == 1'b1, "R3 fast unknown gives up", int'(cmd_up), 1);
    check(n >= 1 && n <= 10, "R7 at most one strobe per syn period", n, 10);

    // R4: synthesizer clearly faster
    set_gen(20, 6);
    steps(200);
    check(cmd_up == 1'b0, "R4 fast synth gives down", int'(cmd_up), 0);

    // R9: equal aligned waves force no decision
    do_srst();
    set_gen(10, 10);
    steps(200);
    check(decided == 1'b0, "R9 equal aligned no decision", int'(decided), 0);

    // R9: alternating bursts toggle the command
    tg = 0; prev = int'(cmd_up);
    for (int b = 0; b < 6; b++) begin
      if (b % 2 == 0) set_gen(6, 20); else set_gen(20, 6);
      for (int k = 0; k < 120; k++) begin
        step();
        if (int'(cmd_up) != prev) tg++;
        prev = int'(cmd_up);
      end
    end
    check(tg >= 5, "R9 command toggles with bursts", tg, 5);

    // R8: asynchronous reset in mid-run
    rst_n = 1'b0;
    #1;
    check(!cmd_up && !decided && !dec_stb, "R8 async reset immediate", int'({cmd_up, decided, dec_stb}), 0);
    steps(2);
    rst_n = 1'b1;
    steps(20);

    set_gen(0, 0);
    steps(8);
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule